// File: doc/BRIEF.md
# External Clock Pin Edge Strobe Generator

This block takes a free-running, asynchronous clock or event signal arriving on a device pin and turns each selected transition of it into a strobe one system clock cycle wide. A downstream counter then advances once per strobe, so an external event stream can drive a timer that lives entirely in the system clock domain.

The pin is captured in two steps. A half-cycle stage takes its value while the system clock is in its high phase and holds it through the low phase. A rising-edge register then re-samples that held value. A history register keeps the previous synchronized level, and the strobe logic compares the two. A three-bit clock-select field picks the edge: code 7 counts rising pin edges, code 6 counts falling pin edges, and every other code produces no strobe. The strobe itself is registered, so a counter fed by it updates 2.5 to 3.5 system clock cycles after the pin edge.

The pin must stay at each level for more than one system clock period, so its frequency is below half the system clock. The clock-select field should be changed only while the pin has been steady for at least one cycle. After reset the detector stays quiet until its history holds a real pin sample, so a pin that is already high is not mistaken for an edge.

Top module: `extclk_sync_edge`

## Requirements
- R1: While rst_n is low, and in the first two system clock cycles after it is released, cnt_pulse is 0.
- R2: If the pin is held high through reset and afterwards, with clk_sel = 7, no strobe is produced after reset is released.
- R3: With clk_sel = 7, each low-to-high pin transition produces exactly one strobe, and high-to-low transitions produce none.
- R4: With clk_sel = 6, each high-to-low pin transition produces exactly one strobe, and low-to-high transitions produce none.
- R5: With clk_sel at any code other than 6 or 7 (for example 0, 3 or 5), pin transitions produce no strobe.
- R6: cnt_pulse is never high in two consecutive system clock cycles.
- R7: A pin change made during the high clock phase that follows rising clock edge k gives cnt_pulse high in exactly the cycle after rising edge k+2. A change made during the low phase that follows rising edge k gives the strobe in the cycle after rising edge k+3.
- R8: A train of pin toggles whose levels each last two system clock cycles produces one strobe per selected edge, none merged and none lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; rising edge registers, high phase opens the first capture stage |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| ext_pin | input | 1 | Asynchronous external clock or event pin |
| clk_sel | input | SEL_W (3) | Clock-select code: 7 counts rising pin edges, 6 counts falling pin edges, others idle |
| cnt_pulse | output | 1 | One-cycle count strobe, registered |

## Verification
The bench changes the pin in both the high and the low clock phase and predicts the exact strobe cycle for each. A design with one stage too many or too few, or with its first stage on the wrong phase, would put the strobe one cycle off and fail the latency comparison. Reset is released with the pin already high, which catches a history register that starts at zero and reports a rising edge that never happened. Dense toggle trains and the idle codes expose strobes that stretch over two cycles, edges that merge, and decoding that counts on codes other than 6 and 7.

// File: rtl/extclk_pkg.sv
package extclk_pkg;

  // Which pin transition, if any, becomes a count strobe.
  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2
  } edge_mode_e;

endpackage

// File: rtl/extclk_capture.sv
// Two-step capture of the asynchronous pin: a half-cycle stage that holds the
// level seen during the high clock phase, then a rising-edge re-sample.
module extclk_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic sample_o
);

  logic half_q;
  logic full_q;

  // Closes on the falling edge, so at the next rising edge it presents the
  // pin value from the end of the high phase.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
    end else begin
      half_q <= pin_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else begin
      full_q <= half_q;
    end
  end

  assign sample_o = full_q;

endmodule

// File: rtl/extclk_edge.sv
// History register, warm-up gate and registered strobe.
module extclk_edge
  import extclk_pkg::*;
#(
  parameter int ARM_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_i,
  input  edge_mode_e mode_i,
  output logic       strobe_o
);

  localparam int ARM_W = $clog2(ARM_CYCLES + 1);
  localparam logic [ARM_W-1:0] ARM_DONE = ARM_W'(ARM_CYCLES);

  logic             prev_q;
  logic [ARM_W-1:0] arm_q;
  logic [ARM_W-1:0] arm_d;
  logic             armed;
  logic             hit;
  logic             strobe_q;
  logic             strobe_d;

  // The history counts as a real pin sample only once the warm-up counter is
  // full; before that, any difference is a reset artefact, not an edge.
  always_comb begin
    armed = (arm_q == ARM_DONE);
    arm_d = armed ? arm_q : arm_q + 1'b1;
    unique case (mode_i)
      EDGE_RISE: hit = sample_i & ~prev_q;
      EDGE_FALL: hit = ~sample_i & prev_q;
      default:   hit = 1'b0;
    endcase
    strobe_d = armed & hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      arm_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      prev_q   <= sample_i;
      arm_q    <= arm_d;
      strobe_q <= strobe_d;
    end
  end

  assign strobe_o = strobe_q;

endmodule

// File: rtl/extclk_sync_edge.sv
module extclk_sync_edge
  import extclk_pkg::*;
#(
  parameter int SEL_W    = 3,
  parameter int SEL_RISE = 7,
  parameter int SEL_FALL = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_pin,
  input  logic [SEL_W-1:0] clk_sel,
  output logic             cnt_pulse
);

  localparam logic [SEL_W-1:0] RISE_CODE = SEL_W'(SEL_RISE);
  localparam logic [SEL_W-1:0] FALL_CODE = SEL_W'(SEL_FALL);
  // One cycle to load the synchronized level, one more to load the history.
  localparam int WARMUP = 2;

  logic       sync_lvl;
  edge_mode_e mode;

  always_comb begin
    if (clk_sel == RISE_CODE) begin
      mode = EDGE_RISE;
    end else if (clk_sel == FALL_CODE) begin
      mode = EDGE_FALL;
    end else begin
      mode = EDGE_NONE;
    end
  end

  extclk_capture u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_i    (ext_pin),
    .sample_o (sync_lvl)
  );

  extclk_edge #(
    .ARM_CYCLES (WARMUP)
  ) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_i (sync_lvl),
    .mode_i   (mode),
    .strobe_o (cnt_pulse)
  );

endmodule

// File: rtl/extclk_sync_edge_chk.sv
module extclk_sync_edge_chk #(
  parameter int SEL_W    = 3,
  parameter int SEL_RISE = 7,
  parameter int SEL_FALL = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ext_pin,
  input logic [SEL_W-1:0] clk_sel,
  input logic             cnt_pulse
);

  localparam logic [SEL_W-1:0] RISE_CODE = SEL_W'(SEL_RISE);
  localparam logic [SEL_W-1:0] FALL_CODE = SEL_W'(SEL_FALL);

  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= 2'd0;
    end else if (since_rst != 2'd3) begin
      since_rst <= since_rst + 2'd1;
    end
  end

  AST_NO_EARLY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_pulse |-> (since_rst >= 2'd2)); // R1

  AST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_pulse |=> !cnt_pulse); // R6

  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel != RISE_CODE && clk_sel != FALL_CODE) |=> !cnt_pulse); // R5

  AST_RISE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_pulse && $past(clk_sel) == RISE_CODE) |-> $past(ext_pin, 2)); // R3

  AST_FALL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_pulse && $past(clk_sel) == FALL_CODE) |-> !$past(ext_pin, 2)); // R4

endmodule

bind extclk_sync_edge extclk_sync_edge_chk #(
  .SEL_W    (SEL_W),
  .SEL_RISE (SEL_RISE),
  .SEL_FALL (SEL_FALL)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ext_pin   (ext_pin),
  .clk_sel   (clk_sel),
  .cnt_pulse (cnt_pulse)
);

// File: tb/sim_extclk_sync_edge.sv
`timescale 1ns/1ps
module sim_extclk_sync_edge;

  logic       clk;
  logic       rst_n;
  logic       ext_pin;
  logic [2:0] clk_sel;
  logic       cnt_pulse;

  int checks;
  int errors;
  int cyc;
  int expq[$];
  string tag;
  bit done;
  bit prev_seen;

  extclk_sync_edge u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_pin   (ext_pin),
    .clk_sel   (clk_sel),
    .cnt_pulse (cnt_pulse)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  always @(posedge clk) cyc <= cyc + 1;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Monitor: sample mid-cycle, pop the predicted cycle for every strobe seen.
  always @(negedge clk) begin
    if (rst_n && cnt_pulse) begin
      checks++;
      if (prev_seen) begin
        errors++;
        $display("FAIL R6 strobe high two cycles running at cycle %0d: actual 1 expected 0", cyc);
      end
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL %s unexpected strobe at cycle %0d: actual 1 expected 0", tag, cyc);
      end else begin
        int e;
        e = expq.pop_front();
        if (e != cyc) begin
          errors++;
          $display("FAIL %s R7 strobe cycle: actual %0d expected %0d", tag, cyc, e);
        end
      end
    end
    prev_seen = rst_n && cnt_pulse;
  end

  // Driver: move the pin in the chosen clock phase, predict the strobe cycle.
  task automatic drive(input logic lvl, input bit low_phase, input int hold);
    bit want;
    want = (clk_sel == 3'd7 && lvl && !ext_pin) ||
           (clk_sel == 3'd6 && !lvl && ext_pin);
    if (low_phase) begin
      @(negedge clk); #2;
      if (want) expq.push_back(cyc + 3);
    end else begin
      @(posedge clk); #2;
      if (want) expq.push_back(cyc + 2);
    end
    ext_pin = lvl;
    repeat (hold) @(posedge clk);
  endtask

  task automatic drained(input string req);
    repeat (6) @(posedge clk);
    #3;
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL %s missing strobes: actual %0d pending expected 0", req, expq.size());
      expq.delete();
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #3;
    checks++;
    if (cnt_pulse !== 1'b0) begin
      errors++;
      $display("FAIL R1 strobe during reset: actual %b expected 0", cnt_pulse);
    end
    @(posedge clk); #2;
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    checks = 0; errors = 0; cyc = 0; done = 0; prev_seen = 0;
    ext_pin = 1'b0; clk_sel = 3'd0; tag = "R1";
    do_reset();
    drained("R1");

    tag = "R3"; clk_sel = 3'd7;
    repeat (3) @(posedge clk);
    drive(1'b1, 1'b0, 4);
    drive(1'b0, 1'b0, 4);
    drive(1'b1, 1'b1, 4);
    drive(1'b0, 1'b1, 4);
    drained("R3");

    tag = "R4"; clk_sel = 3'd6;
    repeat (3) @(posedge clk);
    drive(1'b1, 1'b1, 4);
    drive(1'b0, 1'b1, 4);
    drive(1'b1, 1'b0, 4);
    drive(1'b0, 1'b0, 4);
    drained("R4");

    tag = "R5";
    for (int c = 0; c < 3; c++) begin
      clk_sel = (c == 0) ? 3'd0 : (c == 1) ? 3'd3 : 3'd5;
      repeat (3) @(posedge clk);
      drive(1'b1, 1'b0, 3);
      drive(1'b0, 1'b1, 3);
      drained("R5");
    end

    tag = "R8"; clk_sel = 3'd7;
    repeat (3) @(posedge clk);
    for (int i = 0; i < 12; i++) drive(~ext_pin, i[0], 2);
    drained("R8");
    clk_sel = 3'd0;
    repeat (3) @(posedge clk);
    ext_pin = 1'b1;
    repeat (3) @(posedge clk);
    clk_sel = 3'd6;
    repeat (3) @(posedge clk);
    for (int i = 0; i < 10; i++) drive(~ext_pin, ~i[0], 2);
    drained("R8");

    tag = "R2"; clk_sel = 3'd7;
    ext_pin = 1'b1;
    repeat (3) @(posedge clk);
    do_reset();
    drained("R2");
    drive(1'b0, 1'b0, 4);
    drive(1'b1, 1'b0, 4);
    drained("R2");

    done = 1;
    summary();
  end

endmodule